// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block configures a target FPGA over its slave-serial port. A single start pulse begins the sequence. The loader pulls the target's active-low program pin, waits for the target to report that it is clearing its configuration memory, and releases the program pin. It then waits for the target to report that it is ready. After that it takes bitstream bytes from a valid/ready stream and shifts each one out on a data pin, timed by a configuration clock that it generates itself.

After the byte flagged as last, the loader holds the data pin high. It keeps pulsing the configuration clock until the target raises its done pin. Each waiting phase has its own timeout, measured from the start of that phase. Before each byte is fetched, the loader checks whether the target has flagged a checksum error.

The result appears on sticky busy, success and failure flags. A failure carries a cause code. The configuration clock half-period is set by `STEP_CYC` system clocks, and every wait limit is set by `TIMEOUT_CYC` system clocks. The target's INIT and DONE inputs pass through two-flop synchronisers before the sequencer uses them.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset and whenever idle, prog_n=1, cclk=1 and din=1. Also busy=0 and in_ready=0; after reset ok=0, fail=0 and fail_code=0.
- R2: A start pulse while idle sets busy=1 and drives prog_n=0 on the next clock. If init_n does not go low within TIMEOUT_CYC clocks, the load ends with fail=1 and fail_code=1.
- R3: prog_n returns high only after init_n has been seen low, followed by one step delay. If init_n does not then return high within TIMEOUT_CYC clocks, the load ends with fail=1 and fail_code=2.
- R4: Before each byte is fetched, done=0 together with init_n=0 aborts the load at once with fail=1 and fail_code=3. No further byte is accepted.
- R5: Each accepted byte is sent MSB first, one bit per rising edge of cclk. din changes only while cclk is low, and it is stable for a full step before the rising edge.
- R6: After the byte marked by in_last, and one step delay, din is held at 1. cclk keeps pulsing until done=1, and then the load ends with ok=1 and fail_code=0.
- R7: If done does not rise within TIMEOUT_CYC clocks of the start of the completion phase, the load ends with fail=1 and fail_code=4.
- R8: in_ready is 1 only while the loader is waiting for a byte and no checksum error is present; it is 0 in every other phase.
- R9: ok, fail and fail_code hold their values until the next start. A start pulse while busy=1 has no effect on the pins or on the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration sequence (ignored while busy) |
| in_data | input | DATA_W | Bitstream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte is the final one |
| in_ready | output | 1 | Byte is taken on this clock when in_valid is set |
| prog_n | output | 1 | Active-low program pin of the target |
| cclk | output | 1 | Configuration clock to the target |
| din | output | 1 | Serial configuration data to the target |
| init_n | input | 1 | Target INIT pin, low while clearing or on checksum error |
| done | input | 1 | Target DONE pin, high once configured |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Last sequence succeeded |
| fail | output | 1 | Last sequence failed |
| fail_code | output | 3 | Cause: 1 INIT start, 2 INIT clear, 3 checksum, 4 DONE timeout |

## Verification
A wrong sequencer state shows up at the pins within one step delay. If the clock phase is wrong, or a bit is dropped or reordered, the stream of din values sampled at each cclk rising edge no longer matches the queued bytes, and this is visible at the very next edge. A wrong timer or synchroniser state shows up later, when a load ends too soon or too late, or ends with the wrong cause code. The bench therefore checks the final flags and code of every load, including loads where a target model withholds INIT, DONE or a clean checksum.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_LO,
        ST_PROG_HOLD,
        ST_INIT_HI,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_DAT,
        ST_BIT_HI,
        ST_TAIL,
        ST_DONE_CHK,
        ST_DONE_LO,
        ST_DONE_HI
    } ld_state_e;

    typedef enum logic [2:0] {
        FC_NONE       = 3'd0,
        FC_INIT_START = 3'd1,
        FC_INIT_CLEAR = 3'd2,
        FC_CRC        = 3'd3,
        FC_DONE_TMO   = 3'd4
    } fail_code_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        logic [STAGES-1:0] sh_d;

        always_comb sh_d = {sh_q[STAGES-2:0], d[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RST_VAL[g]}};
            else        sh_q <= sh_d;
        end

        assign q[g] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/cfgl_count.sv
module cfgl_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic hit
);
    localparam int            CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LAST);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STEP_CYC    = 4,
    parameter int TIMEOUT_CYC = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              prog_n,
    output logic              cclk,
    output logic              din,
    input  logic              init_n,
    input  logic              done,
    output logic              busy,
    output logic              ok,
    output logic              fail,
    output logic [2:0]        fail_code
);
    localparam int            BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        ld_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [BW-1:0]     bit_idx;
        logic              last;
        logic              prog_n;
        logic              cclk;
        logic              din;
        logic              busy;
        logic              ok;
        logic              fail;
        fail_code_e        code;
    } ld_regs_t;

    localparam ld_regs_t REG_RST = '{
        st: ST_IDLE, sh: '0, bit_idx: '0, last: 1'b0,
        prog_n: 1'b1, cclk: 1'b1, din: 1'b1,
        busy: 1'b0, ok: 1'b0, fail: 1'b0, code: FC_NONE
    };

    ld_regs_t r_q, r_d;

    logic [1:0] pins_s;
    logic       init_n_s, done_s;
    logic       step_clr, step_hit;
    logic       tmo_clr, tmo_hit;
    logic       crc_err;

    cfgl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({done, init_n}), .q(pins_s)
    );
    assign init_n_s = pins_s[0];
    assign done_s   = pins_s[1];

    cfgl_count #(.LIMIT(STEP_CYC)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(step_clr), .hit(step_hit)
    );

    cfgl_count #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .hit(tmo_hit)
    );

    function automatic ld_regs_t wrap_up(input ld_regs_t cur, input logic good,
                                         input fail_code_e why);
        ld_regs_t n = cur;
        n.st     = ST_IDLE;
        n.busy   = 1'b0;
        n.prog_n = 1'b1;
        n.cclk   = 1'b1;
        n.din    = 1'b1;
        n.ok     = good;
        n.fail   = !good;
        n.code   = why;
        return n;
    endfunction

    assign crc_err = !done_s && !init_n_s;

    always_comb begin
        r_d     = r_q;
        tmo_clr = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_PROG_LO;
                    r_d.prog_n = 1'b0;
                    r_d.busy   = 1'b1;
                    r_d.ok     = 1'b0;
                    r_d.fail   = 1'b0;
                    r_d.code   = FC_NONE;
                    tmo_clr    = 1'b1;
                end
            end
            ST_PROG_LO: begin
                if (!init_n_s)    r_d.st = ST_PROG_HOLD;
                else if (tmo_hit) r_d = wrap_up(r_q, 1'b0, FC_INIT_START);
            end
            ST_PROG_HOLD: begin
                if (step_hit) begin
                    r_d.st     = ST_INIT_HI;
                    r_d.prog_n = 1'b1;
                    tmo_clr    = 1'b1;
                end
            end
            ST_INIT_HI: begin
                if (init_n_s)     r_d.st = ST_FETCH;
                else if (tmo_hit) r_d = wrap_up(r_q, 1'b0, FC_INIT_CLEAR);
            end
            ST_FETCH: begin
                if (crc_err) begin
                    r_d = wrap_up(r_q, 1'b0, FC_CRC);
                end else if (in_valid) begin
                    r_d.sh      = in_data;
                    r_d.last    = in_last;
                    r_d.bit_idx = '0;
                    r_d.st      = ST_BIT_LO;
                    r_d.cclk    = 1'b0;
                end
            end
            ST_BIT_LO: begin
                if (step_hit) begin
                    r_d.st  = ST_BIT_DAT;
                    r_d.din = r_q.sh[DATA_W-1];
                end
            end
            ST_BIT_DAT: begin
                if (step_hit) begin
                    r_d.st   = ST_BIT_HI;
                    r_d.cclk = 1'b1;
                end
            end
            ST_BIT_HI: begin
                if (step_hit) begin
                    if (r_q.bit_idx == LAST_BIT) begin
                        r_d.st = r_q.last ? ST_TAIL : ST_FETCH;
                    end else begin
                        r_d.st      = ST_BIT_LO;
                        r_d.cclk    = 1'b0;
                        r_d.sh      = r_q.sh << 1;
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (step_hit) begin
                    r_d.st  = ST_DONE_CHK;
                    r_d.din = 1'b1;
                    tmo_clr = 1'b1;
                end
            end
            ST_DONE_CHK: begin
                if (done_s) begin
                    r_d = wrap_up(r_q, 1'b1, FC_NONE);
                end else if (tmo_hit) begin
                    r_d = wrap_up(r_q, 1'b0, FC_DONE_TMO);
                end else begin
                    r_d.st   = ST_DONE_LO;
                    r_d.cclk = 1'b0;
                end
            end
            ST_DONE_LO: begin
                if (step_hit) begin
                    r_d.st   = ST_DONE_HI;
                    r_d.cclk = 1'b1;
                end
            end
            ST_DONE_HI: begin
                if (step_hit) r_d.st = ST_DONE_CHK;
            end
            default: r_d = REG_RST;
        endcase
        step_clr = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    assign in_ready  = (r_q.st == ST_FETCH) && !crc_err;
    assign prog_n    = r_q.prog_n;
    assign cclk      = r_q.cclk;
    assign din       = r_q.din;
    assign busy      = r_q.busy;
    assign ok        = r_q.ok;
    assign fail      = r_q.fail;
    assign fail_code = r_q.code;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_ready,
    input logic       prog_n,
    input logic       cclk,
    input logic       din,
    input logic       busy,
    input logic       ok,
    input logic       fail,
    input logic [2:0] fail_code
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && cclk && din));

    // R2
    prog_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !prog_n);

    // R5
    din_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(cclk)) |-> $stable(din));

    // R8
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && prog_n && cclk));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ok) && $stable(fail) && $stable(fail_code)));

    // R7
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_code != 3'd0 && fail_code <= 3'd4 && !ok));

    // R6
    ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (fail_code == 3'd0 && !busy));
endmodule

bind cfg_serial_loader cfgl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
    .prog_n(prog_n), .cclk(cclk), .din(din), .busy(busy),
    .ok(ok), .fail(fail), .fail_code(fail_code)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
    localparam int STEP = 3;
    localparam int TMO  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready, prog_n, cclk, din, busy, ok, fail;
    logic [2:0] fail_code;
    logic       tgt_init_n = 1'b1;
    logic       tgt_done = 1'b0;

    int checks = 0;
    int errors = 0;

    bit m_init_start = 1, m_init_clear = 1, m_done_ok = 1, m_poke = 0;
    int m_crc_byte = 0, m_nbits = 0;
    int lo_cnt = 0, hi_cnt = 0, rise_cnt = 0;
    bit crc_hit = 0, mdl_cclk = 1, mon_cclk = 1, mon_prog = 1;
    int tail_pulses = 0, accepted = 0;

    logic       exp_bits[$];
    logic [7:0] tx_q[$];

    always #5 clk = ~clk;

    cfg_serial_loader #(.DATA_W(8), .STEP_CYC(STEP), .TIMEOUT_CYC(TMO)) u_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .prog_n(prog_n), .cclk(cclk), .din(din), .init_n(tgt_init_n),
        .done(tgt_done), .busy(busy), .ok(ok), .fail(fail), .fail_code(fail_code)
    );

    task automatic check(input bit cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // target model, away from the active edge
    always @(negedge clk) begin
        if (!busy) begin
            tgt_init_n = 1'b1; tgt_done = 1'b0;
            lo_cnt = 0; hi_cnt = 0; rise_cnt = 0; crc_hit = 0;
        end else if (!prog_n) begin
            lo_cnt++;
            if (m_init_start && lo_cnt >= 4) tgt_init_n = 1'b0;
        end else begin
            if (hi_cnt < 100000) hi_cnt++;
            if (m_init_clear && hi_cnt >= 6 && !crc_hit) tgt_init_n = 1'b1;
            if (cclk && !mdl_cclk) rise_cnt++;
            if (m_crc_byte > 0 && rise_cnt == 8 * m_crc_byte && !crc_hit) begin
                crc_hit = 1; tgt_init_n = 1'b0;
            end
            if (m_done_ok && rise_cnt >= m_nbits + 3) tgt_done = 1'b1;
        end
        mdl_cclk = cclk;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && cclk && !mon_cclk) begin
                if (exp_bits.size() > 0) begin
                    logic b;
                    b = exp_bits.pop_front();
                    check(din == b, "R5 serial bit at cclk rise", din, b);
                end else begin
                    tail_pulses++;
                    check(din == 1'b1, "R6 din high while pulsing for done", din, 1);
                end
            end
            if (busy && prog_n && !mon_prog)
                check(tgt_init_n == 1'b0, "R3 program released before init low", tgt_init_n, 0);
            if (in_ready)
                check(busy && prog_n && cclk, "R8 in_ready outside fetch", {busy, prog_n, cclk}, 7);
        end
        mon_cclk = cclk;
        mon_prog = prog_n;
    end

    task automatic push_byte(input logic [7:0] b, input logic last);
        in_data = b; in_last = last; in_valid = 1'b1;
        while (!in_ready && busy) @(negedge clk);
        if (in_ready) begin
            accepted++;
            for (int k = 7; k >= 0; k--) exp_bits.push_back(b[k]);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_load();
        int nb;
        nb = tx_q.size();
        m_nbits = 8 * nb; tail_pulses = 0; accepted = 0;
        exp_bits.delete();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !prog_n, "R2 busy set and prog_n low after start", {busy, prog_n}, 2);
        for (int i = 0; i < nb; i++) begin
            if (i == 1 && m_poke) begin
                start = 1'b1; @(negedge clk); start = 1'b0;
                check(prog_n && busy, "R9 start while busy disturbed pins", {busy, prog_n}, 3);
            end
            if (!busy) break;
            push_byte(tx_q[i], i == nb - 1);
        end
        while (busy) @(negedge clk);
    endtask

    task automatic expect_end(input bit good, input int code, input string req);
        check(ok == good && fail == !good, {req, " outcome flags"}, {ok, fail}, {good, !good});
        check(fail_code == code, {req, " fail_code"}, fail_code, code);
        check(prog_n && cclk && din, "R1 idle pins after load", {prog_n, cclk, din}, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(prog_n && cclk && din, "R1 pins in reset", {prog_n, cclk, din}, 7);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !ok && !fail && fail_code == 0, "R1 status after reset",
              {busy, ok, fail, fail_code}, 0);
        check(!in_ready, "R1 in_ready after reset", in_ready, 0);

        // normal three-byte load
        tx_q = '{8'hA5, 8'h3C, 8'h81};
        run_load();
        expect_end(1, 0, "R6 normal load");
        check(exp_bits.size() == 0, "R5 all bits clocked", exp_bits.size(), 0);
        check(tail_pulses >= 1, "R6 completion pulses issued", tail_pulses, 1);
        repeat (40) @(negedge clk);
        check(ok && !fail && fail_code == 0, "R9 status held while idle", {ok, fail}, 2);

        // start pulse mid-load is ignored
        m_poke = 1;
        tx_q = '{8'hFF, 8'h00};
        run_load();
        m_poke = 0;
        expect_end(1, 0, "R9 load with stray start");
        check(exp_bits.size() == 0 && accepted == 2, "R9 stream intact", accepted, 2);

        // INIT never asserts
        m_init_start = 0;
        tx_q = '{8'h11};
        run_load();
        m_init_start = 1;
        expect_end(0, 1, "R2 init start timeout");
        check(accepted == 0, "R8 no byte taken before init", accepted, 0);

        // INIT never clears
        m_init_clear = 0;
        run_load();
        m_init_clear = 1;
        expect_end(0, 2, "R3 init clear timeout");

        // checksum error after the first byte
        m_crc_byte = 1;
        tx_q = '{8'h5A, 8'hC3, 8'h0F};
        run_load();
        m_crc_byte = 0;
        expect_end(0, 3, "R4 crc abort");
        check(accepted == 1, "R4 bytes accepted before abort", accepted, 1);

        // DONE never rises
        m_done_ok = 0;
        tx_q = '{8'h96};
        run_load();
        m_done_ok = 1;
        expect_end(0, 4, "R7 done timeout");
        check(tail_pulses >= 3, "R7 pulses during done wait", tail_pulses, 3);

        // recovery after failures
        tx_q = '{8'h01, 8'h80};
        run_load();
        expect_end(1, 0, "R6 load after failures");
        check(exp_bits.size() == 0, "R5 MSB-first stream complete", exp_bits.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule